// File: doc/BRIEF.md
# Fixed-Frame Measurement Result Readout

This block takes a set of finished measurement results (an in-phase and a quadrature integral for each analysis channel, plus the length of the integration as a clock count) and hands them to a host that runs on a clock of its own. A one-cycle `res_valid` pulse in the measurement domain freezes the results in a snapshot register. A toggle carries the news across to the host domain through a two-flop synchronizer. The host then sees `hready` rise.

The host pulses `hstrobe` to start a frame and pulses `hread` once per word. The frame is always 32 double words long, whatever the channel count. Each double word goes out as two host words, low half first. Channel integrals come first, in the order I then Q for each channel. Zeros fill the slots after the last channel. Double word 30 is a zero filler and double word 31 carries the integration clock count. After the last word `hready` falls and stays low until the next snapshot.

The host-side sequencer has three states. `ST_EMPTY` means no unread snapshot. `ST_ARMED` means a snapshot is waiting for a strobe. `ST_STREAM` means words are being read. Its transitions are:
- SNAP: any state goes to `ST_ARMED` with the index cleared when a new snapshot arrives.
- START: `ST_ARMED` or `ST_STREAM` goes to `ST_STREAM` with the index cleared on `hstrobe`.
- STEP: `ST_STREAM` stays in `ST_STREAM`, index plus one, on `hread`.
- DONE: `ST_STREAM` goes to `ST_EMPTY` on `hread` of the last word.

Top module: `result_frame_pipe`

## Requirements
- R1: A frame is exactly 32 double words, that is 64 host words with 16-bit words. `hready` is low in the host cycle after the 64th read.
- R2: Double word 2c holds the I integral of channel c, and double word 2c+1 holds its Q integral. In `res_int`, integral k occupies bits [k*WI +: WI].
- R3: Integrals narrower than 32 bits are sign-extended to 32 bits.
- R4: Double words from 2*NCH up to and including 30 read as zero.
- R5: Double word 31 is the integration clock count `res_tcnt`, zero-extended to 32 bits.
- R6: Host word 2d is bits [15:0] of double word d, and host word 2d+1 is bits [31:16].
- R7: Results are captured on the `res_valid` pulse. Later changes on `res_int` or `res_tcnt` do not alter the frame until the next pulse.
- R8: `hready` rises no sooner than the second host clock edge after the capture edge and no later than 8 host cycles after it.
- R9: `hstrobe` restarts the frame from host word 0, also in the middle of a frame.
- R10: `hread` while `hready` is low has no effect, and `hready` stays low.
- R11: After reset, `hready` is low and `hdata` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement-domain clock |
| rst_n | input | 1 | Measurement-domain reset, active low |
| res_valid | input | 1 | One-cycle pulse: results are complete |
| res_int | input | 2*NCH*WI | Integrals, I and Q per channel, flattened |
| res_tcnt | input | WT | Integration time in clocks |
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| hstrobe | input | 1 | Host starts or restarts a frame |
| hready | output | 1 | An unread frame is available |
| hread | input | 1 | Host takes the current word |
| hdata | output | WH | Current host word |

## Verification
The bench builds the block with three channels, 24-bit integrals, a 20-bit count and a 16-bit host bus. With these values, six slots hold channel data, zero padding shows up in the middle of the frame, and sign extension is visible in every upper half. The two clocks run at unrelated periods, so the synchronizer latency window is exercised. Frames carrying negative, most-negative and all-ones values check that sign and zero extension are handled separately.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
    localparam int FRAME_DW = 32;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_STREAM = 2'd2
    } rd_state_t;
endpackage

// File: rtl/rfr_capture.sv
module rfr_capture #(
    parameter int NCH = 3,
    parameter int WI  = 24,
    parameter int WT  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid,
    input  logic [2*NCH*WI-1:0]   res_int,
    input  logic [WT-1:0]         res_tcnt,
    output logic [2*NCH*WI-1:0]   snap_int,
    output logic [WT-1:0]         snap_t,
    output logic                  snap_tgl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_int <= '0;
            snap_t   <= '0;
            snap_tgl <= 1'b0;
        end else if (res_valid) begin
            snap_int <= res_int;
            snap_t   <= res_tcnt;
            snap_tgl <= ~snap_tgl;
        end
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(snap_t) && $stable(snap_int))); // R7
    AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (snap_t == $past(res_tcnt) && snap_tgl != $past(snap_tgl))); // R7
endmodule

// File: rtl/rfr_sync_pulse.sv
module rfr_sync_pulse (
    input  logic hclk,
    input  logic hrst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic s1, s2, s3;

    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tgl_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pulse = s2 ^ s3;
endmodule

// File: rtl/rfr_seq.sv
module rfr_seq
    import rfr_pkg::*;
#(
    parameter int NWORDS = 64,
    localparam int IW    = $clog2(NWORDS)
) (
    input  logic          hclk,
    input  logic          hrst_n,
    input  logic          new_snap,
    input  logic          hstrobe,
    input  logic          hread,
    output logic          hready,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    rd_state_t st, st_nx;
    logic [IW-1:0] idx_nx;

    always_comb begin
        st_nx  = st;
        idx_nx = idx;
        if (new_snap) begin
            st_nx  = ST_ARMED;
            idx_nx = '0;
        end else begin
            unique case (st)
                ST_EMPTY: ;
                ST_ARMED: begin
                    if (hstrobe) begin
                        st_nx  = ST_STREAM;
                        idx_nx = '0;
                    end
                end
                ST_STREAM: begin
                    if (hstrobe) begin
                        idx_nx = '0;
                    end else if (hread) begin
                        if (idx == LAST) begin
                            st_nx = ST_EMPTY;
                        end else begin
                            idx_nx = idx + 1'b1;
                        end
                    end
                end
                default: st_nx = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            st  <= ST_EMPTY;
            idx <= '0;
        end else begin
            st  <= st_nx;
            idx <= idx_nx;
        end
    end

    always_comb begin
        hready = (st == ST_ARMED) || (st == ST_STREAM);
    end

    AST_IDX_STEP: assert property (@(posedge hclk) disable iff (!hrst_n)
        (st == ST_STREAM && hread && !hstrobe && !new_snap && idx != LAST)
        |=> idx == $past(idx) + 1'b1); // R1
    AST_LAST_DROP: assert property (@(posedge hclk) disable iff (!hrst_n)
        (st == ST_STREAM && hread && !hstrobe && !new_snap && idx == LAST)
        |=> !hready); // R1
    AST_STROBE_RESTART: assert property (@(posedge hclk) disable iff (!hrst_n)
        (hstrobe && hready && !new_snap) |=> (idx == '0 && hready)); // R9
    AST_IDLE_READ: assert property (@(posedge hclk) disable iff (!hrst_n)
        (!hready && !new_snap) |=> !hready); // R10
endmodule

// File: rtl/rfr_wordsel.sv
module rfr_wordsel
    import rfr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int WI  = 24,
    parameter int WT  = 20,
    parameter int WH  = 16,
    localparam int HPD    = 32 / WH,
    localparam int HB     = $clog2(HPD),
    localparam int IW     = $clog2(FRAME_DW * HPD)
) (
    input  logic [2*NCH*WI-1:0] snap_int,
    input  logic [WT-1:0]       snap_t,
    input  logic [IW-1:0]       idx,
    output logic [WH-1:0]       hdata
);
    logic [31:0] dw [FRAME_DW];

    for (genvar k = 0; k < FRAME_DW; k++) begin : g_slot
        if (k < 2 * NCH) begin : g_int
            assign dw[k] = {{(32-WI){snap_int[k*WI+WI-1]}}, snap_int[k*WI +: WI]};
        end else if (k == FRAME_DW - 1) begin : g_cnt
            assign dw[k] = {{(32-WT){1'b0}}, snap_t};
        end else begin : g_pad
            assign dw[k] = '0;
        end
    end

    always_comb begin
        hdata = dw[idx[IW-1:HB]][idx[HB-1:0]*WH +: WH];
    end
endmodule

// File: rtl/result_frame_pipe.sv
module result_frame_pipe
    import rfr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int WI  = 24,
    parameter int WT  = 20,
    parameter int WH  = 16,
    localparam int NWORDS = FRAME_DW * (32 / WH),
    localparam int IW     = $clog2(NWORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid,
    input  logic [2*NCH*WI-1:0] res_int,
    input  logic [WT-1:0]       res_tcnt,
    input  logic                hclk,
    input  logic                hrst_n,
    input  logic                hstrobe,
    output logic                hready,
    input  logic                hread,
    output logic [WH-1:0]       hdata
);
    logic [2*NCH*WI-1:0] snap_int;
    logic [WT-1:0]       snap_t;
    logic                snap_tgl;
    logic                new_snap;
    logic [IW-1:0]       idx;

    rfr_capture #(.NCH(NCH), .WI(WI), .WT(WT)) u_cap (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
        .res_int(res_int), .res_tcnt(res_tcnt),
        .snap_int(snap_int), .snap_t(snap_t), .snap_tgl(snap_tgl)
    );

    rfr_sync_pulse u_sync (
        .hclk(hclk), .hrst_n(hrst_n), .tgl_in(snap_tgl), .pulse(new_snap)
    );

    rfr_seq #(.NWORDS(NWORDS)) u_seq (
        .hclk(hclk), .hrst_n(hrst_n), .new_snap(new_snap),
        .hstrobe(hstrobe), .hread(hread), .hready(hready), .idx(idx)
    );

    rfr_wordsel #(.NCH(NCH), .WI(WI), .WT(WT), .WH(WH)) u_sel (
        .snap_int(snap_int), .snap_t(snap_t), .idx(idx), .hdata(hdata)
    );

    AST_READY_AFTER_SNAP: assert property (@(posedge hclk) disable iff (!hrst_n)
        new_snap |=> (hready && idx == '0)); // R8
endmodule

// File: tb/result_frame_pipe_tb.sv
module result_frame_pipe_tb_top;
    localparam int NCH = 3, WI = 24, WT = 20, WH = 16;

    logic clk = 0, hclk = 0;
    logic rst_n = 0, hrst_n = 0;
    logic res_valid = 0;
    logic [2*NCH*WI-1:0] res_int = '0;
    logic [WT-1:0] res_tcnt = '0;
    logic hstrobe = 0, hread = 0;
    logic hready;
    logic [WH-1:0] hdata;

    int n_chk = 0, n_bad = 0;
    logic signed [WI-1:0] m_int [2*NCH];
    logic [WT-1:0] m_t;

    always #4 clk = ~clk;
    always #5.3 hclk = ~hclk;

    result_frame_pipe #(.NCH(NCH), .WI(WI), .WT(WT), .WH(WH)) dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_int(res_int),
        .res_tcnt(res_tcnt), .hclk(hclk), .hrst_n(hrst_n), .hstrobe(hstrobe),
        .hready(hready), .hread(hread), .hdata(hdata)
    );

    function automatic logic [31:0] exp_dw(int d);
        if (d < 2 * NCH) return 32'(signed'(m_int[d]));
        if (d == 31) return 32'(m_t);
        return 32'd0;
    endfunction

    function automatic logic [15:0] exp_word(int w);
        logic [31:0] v = exp_dw(w / 2);
        return (w % 2 == 0) ? v[15:0] : v[31:16];
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
        end
    endtask

    function automatic string tag(int w);
        int d = w / 2;
        if (d < 2 * NCH) return (w % 2 == 0) ? "R2 R6" : "R3";
        if (d == 31) return "R5";
        return "R4";
    endfunction

    task automatic snap(input logic [WT-1:0] t, input logic signed [WI-1:0] v [2*NCH]);
        for (int k = 0; k < 2 * NCH; k++) begin
            res_int[k*WI +: WI] = v[k];
            m_int[k] = v[k];
        end
        res_tcnt = t;
        m_t = t;
        @(negedge clk) res_valid = 1;
        @(negedge clk) res_valid = 0;
        res_int = '1;
        res_tcnt = '1;
        @(negedge hclk);
        chk(hready == 0, "R8 early", 32'(hready), 0);
        begin
            int waited = 0;
            while (!hready && waited < 8) begin
                @(negedge hclk);
                waited++;
            end
            chk(hready == 1, "R8 late", 32'(hready), 1);
        end
    endtask

    task automatic strobe();
        hstrobe = 1;
        @(negedge hclk) hstrobe = 0;
    endtask

    task automatic read_words(input int from, input int upto);
        for (int w = from; w < upto; w++) begin
            chk(hready == 1, "R1 ready", 32'(hready), 1);
            chk(hdata == exp_word(w), tag(w), 32'(hdata), 32'(exp_word(w)));
            hread = 1;
            @(negedge hclk);
        end
        hread = 0;
    endtask

    logic signed [WI-1:0] pa [2*NCH];

    initial begin
        repeat (3) @(negedge hclk);
        rst_n = 1;
        hrst_n = 1;
        @(negedge hclk);
        chk(hready == 0, "R11 ready", 32'(hready), 0);
        chk(hdata == 0, "R11 data", 32'(hdata), 0);

        hread = 1;
        repeat (4) @(negedge hclk);
        hread = 0;
        chk(hready == 0, "R10", 32'(hready), 0);

        pa = '{24'sd1234, -24'sd5, 24'sh12_3456, -24'sd70000, 24'sd0, 24'sh7F_FFFF};
        snap(20'h5A5A5, pa);
        strobe();
        read_words(0, 64);
        chk(hready == 0, "R1 drop", 32'(hready), 0);
        hread = 1;
        @(negedge hclk) hread = 0;
        chk(hready == 0, "R10 after", 32'(hready), 0);

        pa = '{-24'sd1, 24'sd77, -24'sd300, 24'sd9, 24'sd4096, -24'sd2};
        snap(20'h00010, pa);
        strobe();
        read_words(0, 11);
        strobe();
        chk(hdata == exp_word(0), "R9", 32'(hdata), 32'(exp_word(0)));
        read_words(0, 64);
        chk(hready == 0, "R1 drop2", 32'(hready), 0);

        pa = '{24'sh80_0000, 24'sh80_0000, 24'sh7F_FFFF, 24'sh00_8000, 24'sh80_0001, 24'sd1};
        snap(20'hFFFFF, pa);
        strobe();
        read_words(0, 64);
        chk(hready == 0, "R1 drop3", 32'(hready), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge hclk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule